// File: doc/BRIEF.md
# Multi-Lane Serial Bit Mapper

This block sits between a serial memory controller's sequencing logic and the data pins of a single, dual or quad lane serial memory bus. In the outbound direction it takes one data byte and presents it on one, two or four lanes, one bit group per step. In the inbound direction it collects a 24-bit address followed by an 8-bit mode byte from the lanes and reassembles them into parallel fields.

A field begins with a start pulse. The start pulse latches the direction, the lane count and, for outbound fields, the byte. Each later step strobe advances the field by one bit group. Outbound lanes are interleaved with the most significant bit on the highest lane in use. An outbound quad field can begin with a run of don't-care steps, during which no lane is driven. Both directions report the step that completes each 8-bit group and the step that completes the field.

Top module: `lane_mapper`

## Requirements
- R1: With `mode_i`=00 (single) and `dir_i`=0, the byte leaves on lane 0 MSB first, one bit per step, over 8 steps.
- R2: With `mode_i`=01 (dual) and `dir_i`=0, each step carries bit pair (D7,D6), then (D5,D4), (D3,D2), (D1,D0), with the higher bit on lane 1 and the lower on lane 0, over 4 steps.
- R3: With `mode_i`=1x (quad) and `dir_i`=0, the first step drives D7..D4 on lanes 3..0 and the second drives D3..D0.
- R4: When `dummy_i` is 1 at the start of an outbound quad field, 4 steps with all output enables low come before the first nibble. `dummy_i` has no effect in single or dual mode, or when `dir_i`=1.
- R5: Output enables are high exactly on the lanes the current outbound mode uses (0001, 0011 or 1111). When the block is idle, during dummy steps and in inbound fields, all enables are low and `lane_out_o` is 0.
- R6: With `dir_i`=1 in dual mode, 16 steps shift in {A23,A22} down to {A1,A0} and then {M7,M6} down to {M1,M0}, with lane 1 holding the higher bit. `addr_o` and `mode_byte_o` hold the result.
- R7: With `dir_i`=1 in quad mode, 8 steps shift in lanes 3..0 as A23..A20 first, down to M3..M0 last.
- R8: With `dir_i`=1 in single mode, 32 steps shift lane 0 in MSB first.
- R9: `byte_done_o` is high during each step that completes an 8-bit group. `field_done_o` is high during the final step. After that step `busy_o` is 0.
- R10: The mode, direction and dummy selection are sampled only on `start_i`. A change to them during a field has no effect until the next start.
- R11: After reset and between fields, `busy_o` is 0. A step strobe while idle changes neither the lanes nor `addr_o`/`mode_byte_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a field, latching mode, direction, dummy and byte |
| dir_i | input | 1 | 0 = outbound byte, 1 = inbound address and mode |
| mode_i | input | 2 | 00 single, 01 dual, 1x quad |
| dummy_i | input | 1 | Prefix don't-care steps on outbound quad fields |
| step_i | input | 1 | Advance one bit group |
| tx_byte_i | input | 8 | Byte to send |
| lane_in_i | input | 4 | Inbound lane values |
| lane_out_o | output | 4 | Outbound lane values |
| lane_oe_o | output | 4 | Per-lane output enable |
| byte_done_o | output | 1 | Step completes an 8-bit group |
| field_done_o | output | 1 | Step completes the field |
| busy_o | output | 1 | Field in progress |
| addr_o | output | 24 | Reassembled address |
| mode_byte_o | output | 8 | Reassembled mode byte |

## Verification
The outbound bytes are asymmetric patterns such as 0xB4, 0x6D and 0x93. With these, a swapped lane, reversed bit order or wrong group order each produces a visibly different lane sequence. Inbound words use address and mode values with distinct nibbles and bytes. A misplaced shift or lane swap in dual or quad assembly therefore lands on a different value. Dummy-prefixed quad fields, dummy requests in dual mode, a mode change in the middle of a field, and idle strobes separate the correct behaviour from counting or latching mistakes.

// File: rtl/lane_mapper.sv
module lane_mapper #(
  parameter int DUMMY_STEPS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        dir_i,
  input  logic [1:0]  mode_i,
  input  logic        dummy_i,
  input  logic        step_i,
  input  logic [7:0]  tx_byte_i,
  input  logic [3:0]  lane_in_i,
  output logic [3:0]  lane_out_o,
  output logic [3:0]  lane_oe_o,
  output logic        byte_done_o,
  output logic        field_done_o,
  output logic        busy_o,
  output logic [23:0] addr_o,
  output logic [7:0]  mode_byte_o
);
  localparam int OUT_BITS = 8;
  localparam int IN_BITS  = 32;
  localparam int CW = $clog2(IN_BITS + 1);
  localparam int DW = $clog2(DUMMY_STEPS + 1);

  logic          busy_q, dir_q;
  logic [1:0]    wide_q;
  logic [CW-1:0] cnt_q, wbits;
  logic [DW-1:0] dcnt_q;
  logic [31:0]   sh_q, sh_next;
  logic [3:0]    mask, data;
  logic          advance, in_dummy, bit_step, last, drive;

  always_comb begin
    case (wide_q)
      2'b10: begin
        wbits = CW'(4); mask = 4'b1111; data = sh_q[31:28];
        sh_next = {sh_q[27:0], lane_in_i};
      end
      2'b01: begin
        wbits = CW'(2); mask = 4'b0011; data = {2'b00, sh_q[31:30]};
        sh_next = {sh_q[29:0], lane_in_i[1:0]};
      end
      default: begin
        wbits = CW'(1); mask = 4'b0001; data = {3'b000, sh_q[31]};
        sh_next = {sh_q[30:0], lane_in_i[0]};
      end
    endcase
  end

  assign advance  = busy_q & step_i & ~start_i;
  assign in_dummy = dcnt_q != '0;
  assign bit_step = advance & ~in_dummy;
  assign last     = cnt_q == wbits;

  assign byte_done_o  = bit_step & (cnt_q[2:0] == wbits[2:0]);
  assign field_done_o = bit_step & last;
  assign busy_o       = busy_q;

  assign drive      = busy_q & ~dir_q & ~in_dummy;
  assign lane_oe_o  = drive ? mask : 4'b0000;
  assign lane_out_o = drive ? (data & mask) : 4'b0000;

  assign addr_o      = sh_q[31:8];
  assign mode_byte_o = sh_q[7:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
      wide_q <= 2'b00;
      cnt_q  <= '0;
      dcnt_q <= '0;
      sh_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      dir_q  <= dir_i;
      wide_q <= mode_i[1] ? 2'b10 : (mode_i[0] ? 2'b01 : 2'b00);
      cnt_q  <= dir_i ? CW'(IN_BITS) : CW'(OUT_BITS);
      dcnt_q <= (!dir_i && mode_i[1] && dummy_i) ? DW'(DUMMY_STEPS) : '0;
      sh_q   <= dir_i ? 32'h0 : {tx_byte_i, 24'h0};
    end else if (advance) begin
      if (in_dummy) begin
        dcnt_q <= dcnt_q - 1'b1;
      end else begin
        sh_q  <= sh_next;
        cnt_q <= cnt_q - wbits;
        if (last) busy_q <= 1'b0;
      end
    end
  end
endmodule

module lane_mapper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       step_i,
  input logic [3:0] lane_out_o,
  input logic [3:0] lane_oe_o,
  input logic       byte_done_o,
  input logic       field_done_o,
  input logic       busy_o
);
  AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (lane_oe_o == 4'b0000 && lane_out_o == 4'b0000)); // R5
  AST_OE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe_o == 4'b0000 || lane_oe_o == 4'b0001 || lane_oe_o == 4'b0011 || lane_oe_o == 4'b1111)); // R5
  AST_OUT_WITHIN_OE: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_out_o & ~lane_oe_o) == 4'b0000); // R5
  AST_BYTE_DONE_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_o |-> (step_i && busy_o && !start_i)); // R9
  AST_FIELD_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    field_done_o |-> byte_done_o); // R9
  AST_FIELD_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    field_done_o |=> !busy_o); // R9
  AST_HOLD_WITHOUT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !step_i && !start_i) |=> ($stable(lane_oe_o) && $stable(lane_out_o) && busy_o)); // R10
endmodule

bind lane_mapper lane_mapper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .step_i(step_i),
  .lane_out_o(lane_out_o), .lane_oe_o(lane_oe_o), .byte_done_o(byte_done_o),
  .field_done_o(field_done_o), .busy_o(busy_o)
);

// File: tb/sim_lane_mapper.sv
module sim_lane_mapper;
  logic clk = 0, rst_n = 0;
  logic start_i = 0, dir_i = 0, dummy_i = 0, step_i = 0;
  logic [1:0] mode_i = 0;
  logic [7:0] tx_byte_i = 0;
  logic [3:0] lane_in_i = 0;
  logic [3:0] lane_out_o, lane_oe_o;
  logic byte_done_o, field_done_o, busy_o;
  logic [23:0] addr_o;
  logic [7:0] mode_byte_o;

  typedef struct { logic [3:0] out; logic [3:0] oe; logic bd; logic fd; } exp_t;
  exp_t q[$];
  string tq[$];
  int ntest = 0, nfail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  lane_mapper u0 (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    ntest++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (step_i) begin
    exp_t e; string t;
    if (q.size() == 0) begin
      ntest++; nfail++; $display("FAIL scoreboard empty actual=step expected=none");
    end else begin
      e = q.pop_front(); t = tq.pop_front();
      chk({t, " lanes"}, {28'h0, lane_out_o}, {28'h0, e.out});
      chk({t, " oe"}, {28'h0, lane_oe_o}, {28'h0, e.oe});
      chk({t, " byte_done"}, {31'h0, byte_done_o}, {31'h0, e.bd});
      chk({t, " field_done"}, {31'h0, field_done_o}, {31'h0, e.fd});
    end
  end

  task automatic do_step(input logic [3:0] lin, input exp_t e, input string tag);
    lane_in_i = lin; step_i = 1; q.push_back(e); tq.push_back(tag);
    @(posedge clk); #1; step_i = 0;
  endtask

  task automatic begin_field(input logic d, input logic [1:0] m, input logic dm, input logic [7:0] b);
    dir_i = d; mode_i = m; dummy_i = dm; tx_byte_i = b; start_i = 1;
    @(posedge clk); #1; start_i = 0;
  endtask

  task automatic expect_out(input logic [1:0] m, input logic dm, input logic [7:0] b, input string tag);
    int w; logic [3:0] mk;
    w = m[1] ? 4 : (m[0] ? 2 : 1);
    mk = m[1] ? 4'hF : (m[0] ? 4'h3 : 4'h1);
    if (dm && m[1]) for (int k = 0; k < 4; k++) do_step(4'h0, '{4'h0, 4'h0, 1'b0, 1'b0}, "R4 dummy");
    for (int k = 0; k < 8 / w; k++) begin
      logic [3:0] v;
      v = 4'(b >> (8 - w * (k + 1))) & mk;
      do_step(4'h0, '{v, mk, (k == 8 / w - 1), (k == 8 / w - 1)}, tag);
    end
  endtask

  task automatic send_byte(input logic [1:0] m, input logic dm, input logic [7:0] b, input string tag);
    begin_field(1'b0, m, dm, b);
    expect_out(m, dm, b, tag);
    chk({tag, " busy after"}, {31'h0, busy_o}, 32'h0);
  endtask

  task automatic recv(input logic [1:0] m, input logic [23:0] a, input logic [7:0] mb, input string tag);
    logic [31:0] word; int w;
    word = {a, mb};
    w = m[1] ? 4 : (m[0] ? 2 : 1);
    begin_field(1'b1, m, 1'b1, 8'hFF);
    for (int k = 0; k < 32 / w; k++) begin
      logic [3:0] lin;
      lin = 4'(word >> (32 - w * (k + 1)));
      if (w == 2) lin = {2'b10, lin[1:0]};
      if (w == 1) lin = {3'b110, lin[0]};
      do_step(lin, '{4'h0, 4'h0, ((w * (k + 1)) % 8 == 0), (k == 32 / w - 1)}, tag);
    end
    chk({tag, " addr"}, {8'h0, addr_o}, {8'h0, a});
    chk({tag, " mode byte"}, {24'h0, mode_byte_o}, {24'h0, mb});
    chk("R9 busy low after field", {31'h0, busy_o}, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1; ntest++; nfail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1; rst_n = 1;
    chk("R11 reset busy", {31'h0, busy_o}, 32'h0);
    chk("R5 reset oe", {28'h0, lane_oe_o}, 32'h0);
    chk("R5 reset lanes", {28'h0, lane_out_o}, 32'h0);
    send_byte(2'b00, 1'b0, 8'hB4, "R1 single");
    send_byte(2'b00, 1'b1, 8'h6D, "R1 single dummy ignored");
    send_byte(2'b01, 1'b0, 8'hB4, "R2 dual");
    send_byte(2'b01, 1'b1, 8'h93, "R4 dual dummy ignored");
    send_byte(2'b10, 1'b0, 8'hB4, "R3 quad");
    send_byte(2'b11, 1'b0, 8'h6D, "R3 quad 11");
    send_byte(2'b10, 1'b1, 8'h93, "R4 quad dummy");
    recv(2'b01, 24'hC3A51E, 8'h7B, "R6 dual in");
    recv(2'b10, 24'h1F2E3D, 8'h4C, "R7 quad in");
    recv(2'b00, 24'h8421F0, 8'hA6, "R8 single in");
    do_step(4'hF, '{4'h0, 4'h0, 1'b0, 1'b0}, "R11 idle step");
    chk("R11 addr kept", {8'h0, addr_o}, 32'h008421F0);
    chk("R11 mode kept", {24'h0, mode_byte_o}, 32'hA6);
    begin_field(1'b0, 2'b10, 1'b0, 8'hD2);
    mode_i = 2'b00; dir_i = 1'b1; dummy_i = 1'b1;
    expect_out(2'b10, 1'b0, 8'hD2, "R10 mode change ignored");
    chk("R10 busy after", {31'h0, busy_o}, 32'h0);
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", ntest, nfail);
      $finish;
    end
  end
endmodule